// File: doc/BRIEF.md
# Receive Byte Ring Buffer with Hysteretic RTS

This block sits between a serial receiver and the host that consumes its bytes. Each byte offered with a valid strobe is written into a circular store at the head position. The oldest stored byte is always presented on the read data port, and a host read request removes it by advancing the tail. A fill level register tracks how many bytes are held. When the store is full, newly offered bytes are discarded without any indication, and the stored bytes are left as they were.

The block also drives the request-to-send line back to the remote transmitter, with hysteresis. The line falls when a write brings the level up to half the depth. It rises again only when reads bring the level down to a quarter of the depth. Between those two points it keeps its last value. A flow-control enable input bypasses this behaviour and holds RTS asserted. A synchronous flush input empties the store at any time.

Top module: `rx_ring_rts`

## Requirements
- R1: After reset the buffer is empty: `avail` is 0 and `rts` is 1.
- R2: Bytes are returned in the order they were accepted. While `avail` is 1, `rd_data` shows the oldest stored byte. A cycle with `rd_req` high and the buffer non-empty removes that byte.
- R3: A byte offered while the level equals DEPTH is discarded. The level and the stored contents stay unchanged, so the following reads return only the earlier bytes.
- R4: With `fc_en` high, a cycle that only writes and raises the level to DEPTH/2 drives `rts` to 0 on the next cycle.
- R5: With `fc_en` high, a cycle that only reads and lowers the level to DEPTH/4 drives `rts` to 1 on the next cycle.
- R6: At levels strictly between DEPTH/4 and DEPTH/2, `rts` keeps its previous value. It therefore differs between filling and draining.
- R7: A cycle that both accepts a byte and removes one leaves the level unchanged, and `rts` is not re-evaluated on that cycle.
- R8: While `fc_en` is low, `rts` is 1 from the next cycle on, whatever the level.
- R9: A read request while the buffer is empty has no effect: the level stays 0 and `avail` stays 0. If a byte is written in the same cycle, that byte is kept.
- R10: The head and tail positions each wrap from the last entry to the first on their own. Byte order is preserved across any number of wraps.
- R11: `flush` empties the buffer and sets `rts` to 1 on the next cycle. A byte offered in the same cycle is dropped, and the next accepted byte is the first one returned.
- R12: `avail` is 1 exactly when the level is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| flush | input | 1 | Synchronous reinitialise: empties the store and reasserts RTS |
| in_valid | input | 1 | A received byte is offered this cycle |
| in_data | input | DW | Received byte |
| rd_req | input | 1 | Host removes the oldest byte this cycle |
| fc_en | input | 1 | 1: RTS follows the fill thresholds; 0: RTS held asserted |
| rd_data | output | DW | Oldest stored byte, valid while `avail` is 1 |
| avail | output | 1 | At least one byte is stored |
| rts | output | 1 | Request-to-send to the remote transmitter, 1 = send allowed |

## Verification
The properties assume that `flush`, `in_valid`, `rd_req` and `fc_en` are known, single-clock-domain levels sampled at the rising edge. They also assume that `flush` overrides both data strobes in the cycle it is high. The threshold properties take as given that a lone write or a lone read moves the level by exactly one, so a crossing of DEPTH/2 or DEPTH/4 can only happen on such a cycle. The stimulus changes every input only on the falling clock edge and holds all of them at known values from the start of reset. It walks the level from empty to past full and back, runs overlapped write and read at every level, and ends with a long pseudo-random mix of strobes, flow-control toggles and rare flushes.

// File: rtl/rr_pkg.sv
package rr_pkg;
  // Level update chosen for a cycle
  typedef enum logic [1:0] {
    LV_HOLD  = 2'd0,
    LV_UP    = 2'd1,
    LV_DOWN  = 2'd2,
    LV_CLEAR = 2'd3
  } lv_op_e;
endpackage

// File: rtl/rr_ptr.sv
module rr_ptr #(
  parameter int DEPTH = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          adv,
  output logic [AW-1:0] ptr
);
  logic [AW-1:0] ptr_inc;
  logic [AW-1:0] ptr_nxt;
  logic          ptr_en;

  // Wrap: free-running for power-of-two depths, explicit compare otherwise
  generate
    if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      always_comb ptr_inc = ptr + AW'(1);
    end else begin : g_npow2
      always_comb ptr_inc = (ptr == AW'(DEPTH - 1)) ? '0 : ptr + AW'(1);
    end
  endgenerate

  always_comb begin
    ptr_en  = clr | adv;
    ptr_nxt = clr ? '0 : ptr_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr <= '0;
    else if (ptr_en) ptr <= ptr_nxt;
  end
endmodule

// File: rtl/rr_store.sv
module rr_store #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/rr_level.sv
module rr_level
  import rr_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          in_valid,
  input  logic          rd_req,
  input  logic          fc_en,
  output logic          wr_ok,
  output logic          rd_ok,
  output logic [CW-1:0] fill,
  output logic          rts
);
  localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);
  localparam logic [CW-1:0] HI_LVL   = CW'(DEPTH / 2);
  localparam logic [CW-1:0] LO_LVL   = CW'(DEPTH / 4);

  lv_op_e        op;
  logic [CW-1:0] fill_nxt;
  logic          fill_en;
  logic          rts_nxt;
  logic          rts_en;

  always_comb begin
    wr_ok = in_valid & (fill != FULL_LVL);
    rd_ok = rd_req & (fill != '0);
    if (clr)                 op = LV_CLEAR;
    else if (wr_ok & !rd_ok) op = LV_UP;
    else if (rd_ok & !wr_ok) op = LV_DOWN;
    else                     op = LV_HOLD;
  end

  always_comb begin
    unique case (op)
      LV_CLEAR: fill_nxt = '0;
      LV_UP:    fill_nxt = fill + CW'(1);
      LV_DOWN:  fill_nxt = fill - CW'(1);
      default:  fill_nxt = fill;
    endcase
    fill_en = (op != LV_HOLD);
  end

  // Hysteresis: act only on the exact crossing by a lone write or read
  always_comb begin
    rts_nxt = rts;
    if (op == LV_CLEAR || !fc_en)                 rts_nxt = 1'b1;
    else if (op == LV_UP && fill_nxt == HI_LVL)   rts_nxt = 1'b0;
    else if (op == LV_DOWN && fill_nxt == LO_LVL) rts_nxt = 1'b1;
    rts_en = (rts_nxt != rts);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       fill <= '0;
    else if (fill_en) fill <= fill_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rts <= 1'b1;
    else if (rts_en) rts <= rts_nxt;
  end
endmodule

// File: rtl/rx_ring_rts.sv
module rx_ring_rts #(
  parameter int DEPTH = 32,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          rd_req,
  input  logic          fc_en,
  output logic [DW-1:0] rd_data,
  output logic          avail,
  output logic          rts
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic          rst_s1, rst_s2;
  logic          wr_ok, rd_ok;
  logic [AW-1:0] head, tail;
  logic [CW-1:0] fill;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  rr_level #(.DEPTH(DEPTH), .CW(CW)) u_level (
    .clk(clk), .rst_n(rst_s2), .clr(flush),
    .in_valid(in_valid), .rd_req(rd_req), .fc_en(fc_en),
    .wr_ok(wr_ok), .rd_ok(rd_ok), .fill(fill), .rts(rts)
  );

  rr_ptr #(.DEPTH(DEPTH), .AW(AW)) u_head (
    .clk(clk), .rst_n(rst_s2), .clr(flush), .adv(wr_ok & !flush), .ptr(head)
  );

  rr_ptr #(.DEPTH(DEPTH), .AW(AW)) u_tail (
    .clk(clk), .rst_n(rst_s2), .clr(flush), .adv(rd_ok & !flush), .ptr(tail)
  );

  rr_store #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_store (
    .clk(clk), .we(wr_ok & !flush), .waddr(head), .wdata(in_data),
    .raddr(tail), .rdata(rd_data)
  );

  assign avail = (fill != '0);
endmodule

// File: rtl/rr_check.sv
module rr_check #(
  parameter int DEPTH = 32,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flush,
  input logic          in_valid,
  input logic          rd_req,
  input logic          fc_en,
  input logic          rts,
  input logic [CW-1:0] fill
);
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(DEPTH));

  p_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fill == CW'(DEPTH) && in_valid && !rd_req && !flush) |=> (fill == CW'(DEPTH)));

  p_rts_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_en && !flush && in_valid && !rd_req && fill == CW'(DEPTH / 2 - 1)) |=> !rts);

  p_rts_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_en && !flush && rd_req && !in_valid && fill == CW'(DEPTH / 4 + 1)) |=> rts);

  p_overlap_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_en && !flush && in_valid && rd_req && fill != '0 && fill != CW'(DEPTH))
      |=> ($stable(fill) && $stable(rts)));

  p_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !fc_en |=> rts);

  p_empty_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fill == '0 && rd_req && !in_valid && !flush) |=> (fill == '0));

  p_flush_r11: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (fill == '0 && rts));
endmodule

bind rx_ring_rts rr_check #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_s2), .flush(flush), .in_valid(in_valid),
  .rd_req(rd_req), .fc_en(fc_en), .rts(rts), .fill(fill)
);

// File: tb/sim_rx_ring_rts.sv
`timescale 1ns/1ps
module sim_rx_ring_rts;
  localparam int D  = 8;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n, flush, in_valid, rd_req, fc_en;
  logic [DW-1:0] in_data;
  logic [DW-1:0] rd_data;
  logic          avail, rts;

  int n_cmp = 0;
  int n_bad = 0;

  logic [DW-1:0] q[$];
  logic          m_rts;
  logic [15:0]   lf;

  always #2 clk = ~clk;

  rx_ring_rts #(.DEPTH(D), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid),
    .in_data(in_data), .rd_req(rd_req), .fc_en(fc_en),
    .rd_data(rd_data), .avail(avail), .rts(rts)
  );

  task automatic cmp(input string tag, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    cmp(tag, "avail", DW'(avail), DW'(q.size() != 0));
    cmp(tag, "rts", DW'(rts), DW'(m_rts));
    if (q.size() != 0) cmp(tag, "rd_data", rd_data, q[0]);
  endtask

  // Drive one cycle from a falling edge; model the requirements; check at next falling edge
  task automatic cyc(input bit v, input logic [DW-1:0] d, input bit r,
                     input bit fe, input bit fl, input string tag);
    bit wok, rok;
    in_valid = v; in_data = d; rd_req = r; fc_en = fe; flush = fl;
    if (fl) begin
      q.delete();
      m_rts = 1'b1;
    end else begin
      wok = v && (q.size() < D);
      rok = r && (q.size() > 0);
      if (rok) void'(q.pop_front());
      if (wok) q.push_back(d);
      if (!fe)                                  m_rts = 1'b1;
      else if (wok && !rok && q.size() == D/2)  m_rts = 1'b0;
      else if (rok && !wok && q.size() == D/4)  m_rts = 1'b1;
    end
    @(posedge clk);
    @(negedge clk);
    check_all(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; flush = 1'b0; in_valid = 1'b0; rd_req = 1'b0;
    fc_en = 1'b1; in_data = '0; m_rts = 1'b1; lf = 16'hACE1;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_all("R1");

    // Fill past full: R4 falls at level 4, R6 holds, R3 drops bytes 8 and 9
    for (int i = 0; i < 10; i++)
      cyc(1, DW'(8'h10 + i), 0, 1, 0, (i < 4) ? "R4" : ((i < 8) ? "R6" : "R3"));
    // Drain in order: R6 holds above 2, R5 rises at 2, R2 order
    for (int i = 0; i < 8; i++)
      cyc(0, '0, 1, 1, 0, (i < 5) ? "R6" : ((i == 5) ? "R5" : "R2"));
    cyc(0, '0, 1, 1, 0, "R9");
    cyc(0, '0, 1, 1, 0, "R9");
    cyc(1, 8'h77, 1, 1, 0, "R9");
    cyc(0, '0, 1, 1, 0, "R12");

    // Overlapped write and read at every level
    for (int k = 1; k < D; k++) begin
      for (int i = 0; i < k; i++) cyc(1, DW'(k * 16 + i), 0, 1, 0, "R7");
      for (int i = 0; i < 3; i++) cyc(1, DW'(8'hA0 + i), 1, 1, 0, "R7");
      cyc(0, '0, 0, 1, 1, "R11");
    end
    for (int i = 0; i < D; i++) cyc(1, DW'(i), 0, 1, 0, "R3");
    cyc(1, 8'hEE, 1, 1, 0, "R3");
    cyc(0, '0, 0, 1, 1, "R11");

    // Flow control bypassed
    for (int i = 0; i < D; i++) cyc(1, DW'(8'h40 + i), 0, 0, 0, "R8");
    for (int i = 0; i < D; i++) cyc(0, '0, 1, 0, 0, "R8");

    // Wrapping pointers
    for (int i = 0; i < 3; i++) cyc(1, DW'(8'h60 + i), 0, 1, 0, "R10");
    for (int i = 0; i < 5 * D; i++) cyc(1, DW'(8'h63 + i), 1, 1, 0, "R10");
    for (int i = 0; i < 3; i++) cyc(0, '0, 1, 1, 0, "R10");

    // Flush mid-fill, with a byte offered in the same cycle
    for (int i = 0; i < 5; i++) cyc(1, DW'(8'h90 + i), 0, 1, 0, "R11");
    cyc(1, 8'hBB, 0, 1, 1, "R11");
    cyc(1, 8'hC3, 0, 1, 0, "R11");
    cyc(0, '0, 1, 1, 0, "R11");

    // Pseudo-random walk, biased to fill then drain
    for (int i = 0; i < 3000; i++) begin
      bit v, r;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      v = ((i / 200) % 2 == 0) ? (lf[0] | lf[1]) : (lf[0] & lf[1]);
      r = ((i / 200) % 2 == 0) ? (lf[3] & lf[4]) : (lf[3] | lf[4]);
      cyc(v, lf[15:8], r, lf[7:5] != 3'd0, lf[12:8] == 5'd0, "R12");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule